// File: doc/BRIEF.md
# Multi-channel prescaled down-counter timer unit

This block is a memory-mapped timer peripheral. A single 16-bit prescaler divides the system clock into a tick strobe. That strobe is shared by a parameterised number of 32-bit down-counting channels, from one to eight. Each channel has a counter, a reload value and a control word. Software can start a channel by copying the reload value into the counter, or by writing the counter directly.

On every tick an enabled channel counts down by one. It expires when it would drop below zero, so a loaded value N gives N+1 ticks. On expiry the channel either reloads and keeps running, or stops. If its interrupt enable is set, the channel raises a sticky pending flag and pulses its own interrupt line. The pending flag is cleared by writing a one to its position. A read-only capability word reports the channel count and the interrupt layout.

Access is through a simple word bus. A write takes effect at the clock edge where `sel` and `we` are high. A read is requested with `sel` high and `we` low, and its data appears on `rdata` in the following cycle.

Top module: `tmr_unit`

## Requirements
- R1: After reset the following registers read 0: the prescaler value (0x00), the prescaler reload (0x04), and every channel counter, reload and control word. All interrupt lines are low.
- R2: The capability word at 0x08 is read-only and ignores writes. It holds the channel count in bits [2:0] (8 encodes as 0), the interrupt base number in bits [7:3], and a one in bit 8 and in bit 9. With the defaults (2 channels, base 8) it reads 0x342.
- R3: Address map and read timing:
  - Channel n uses the window 0x10·(n+1): the counter at +0x0, the reload at +0x4 and the control word at +0x8.
  - A read presents its data on `rdata` in the cycle after the request.
  - The following read as 0, and writes to them are ignored: offset 0x0C of any window, channels that do not exist, and addresses whose bits [1:0] are not zero.
- R4: The prescaler value and the prescaler reload keep only the low 16 bits of a write. A write to the prescaler reload also loads the prescaler counter. With reload P, ticks occur every P+1 clocks: the first tick comes P clocks after the cycle that follows that write.
- R5: An enabled channel loaded with N expires on its (N+1)th tick. If the interrupt is enabled, its line is high in the cycle after the expiring tick.
- R6: Interrupt behaviour on expiry:
  - With interrupt enable (control bit 3) set, an expiry sets pending (bit 4) and raises the interrupt line for exactly that one cycle, unless the next tick is also an expiry.
  - With interrupt enable clear, neither the pending flag nor the line changes.
- R7: Restart and one-shot modes:
  - With restart (bit 1) set, an expired channel reloads from its reload register and runs on, expiring every (N+1)·(P+1) clocks.
  - With restart clear, the channel clears its enable (bit 0) and stops.
- R8: Writing the control word with bit 4 set clears pending. Writing it with bit 4 clear leaves pending unchanged. Nothing else clears pending.
- R9: Writing the control word with load (bit 2) set copies the reload value into the counter. The load bit always reads back 0. A write to a channel's counter or control word consumes any tick that occurs in that same cycle.
- R10: A write to the counter sets the count. If the channel is enabled, it counts on from that value.
- R11: Control bits 5 and 6 are stored and read back, and they have no effect on counting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sel | input | 1 | Bus access request |
| we | input | 1 | Access is a write when high, a read when low |
| addr | input | 8 | Byte address of the access |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid the cycle after a read request |
| irq | output | NCH | One interrupt line per channel |

## Verification
The assertions assume that `sel`, `we`, `addr` and `wdata` are never unknown once reset is released. They also assume that each access lasts exactly one cycle and that reset is held for at least one edge at start-up. The bench drives every bus signal at the falling edge, holds each access for one rising edge, and drops `sel` between sequences. Misaligned and unmapped addresses are used only in deliberate probes. The bench avoids a zero reload combined with a zero prescaler in restart mode, because that setting would keep an interrupt line high continuously.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    localparam int unsigned DW = 32;

    // control word bit positions (software visible)
    localparam int unsigned B_EN  = 0;
    localparam int unsigned B_RS  = 1;
    localparam int unsigned B_LD  = 2;
    localparam int unsigned B_IE  = 3;
    localparam int unsigned B_IP  = 4;
    localparam int unsigned B_CH  = 5;
    localparam int unsigned B_DH  = 6;

    typedef enum logic [1:0] {
        W_VAL  = 2'd0,
        W_RLD  = 2'd1,
        W_CTL  = 2'd2,
        W_NONE = 2'd3
    } word_e;

    typedef struct packed {
        logic dh;
        logic ch;
        logic ip;
        logic ie;
        logic rs;
        logic en;
    } ch_ctl_t;

    function automatic logic [DW-1:0] ctl_to_word(ch_ctl_t c);
        logic [DW-1:0] w;
        w = '0;
        w[B_EN] = c.en;
        w[B_RS] = c.rs;
        w[B_IE] = c.ie;
        w[B_IP] = c.ip;
        w[B_CH] = c.ch;
        w[B_DH] = c.dh;
        return w;
    endfunction

    function automatic logic [DW-1:0] cap_word(int unsigned nch, int unsigned base);
        logic [DW-1:0] w;
        w = '0;
        w[2:0] = 3'(nch);
        w[7:3] = 5'(base);
        w[8]   = 1'b1;
        w[9]   = 1'b1;
        return w;
    endfunction

endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
    parameter int unsigned PW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_val,
    input  logic          wr_rld,
    input  logic [PW-1:0] wdata,
    output logic          tick,
    output logic [PW-1:0] cnt_o,
    output logic [PW-1:0] rld_o
);
    logic [PW-1:0] cnt_q;
    logic [PW-1:0] rld_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            rld_q <= '0;
        end else if (wr_rld) begin
            rld_q <= wdata;
            cnt_q <= wdata;
        end else if (wr_val) begin
            cnt_q <= wdata;
        end else if (cnt_q == '0) begin
            cnt_q <= rld_q;
        end else begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign tick  = (cnt_q == '0);
    assign cnt_o = cnt_q;
    assign rld_o = rld_q;
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
    import tmr_pkg::*;
#(
    parameter int unsigned CW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick,
    input  logic          wr_cnt,
    input  logic          wr_rld,
    input  logic          wr_ctl,
    input  logic [CW-1:0] wdata,
    output logic [CW-1:0] cnt_o,
    output logic [CW-1:0] rld_o,
    output ch_ctl_t       ctl_o,
    output logic          irq
);
    logic [CW-1:0] cnt_q;
    logic [CW-1:0] rld_q;
    ch_ctl_t       ctl_q;
    logic          step;
    logic          expire;

    // a bus write to this channel's counter or control consumes the tick
    always_comb begin
        step   = tick && ctl_q.en && !wr_cnt && !wr_ctl;
        expire = step && (cnt_q == '0);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (wr_cnt) begin
            cnt_q <= wdata;
        end else if (wr_ctl && wdata[B_LD]) begin
            cnt_q <= rld_q;
        end else if (expire) begin
            if (ctl_q.rs) cnt_q <= rld_q;
        end else if (step) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) rld_q <= '0;
        else if (wr_rld) rld_q <= wdata;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q <= '0;
        end else if (wr_ctl) begin
            ctl_q.en <= wdata[B_EN];
            ctl_q.rs <= wdata[B_RS];
            ctl_q.ie <= wdata[B_IE];
            ctl_q.ch <= wdata[B_CH];
            ctl_q.dh <= wdata[B_DH];
            ctl_q.ip <= wdata[B_IP] ? 1'b0 : ctl_q.ip;
        end else if (expire) begin
            if (ctl_q.ie) ctl_q.ip <= 1'b1;
            if (!ctl_q.rs) ctl_q.en <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) irq <= 1'b0;
        else     irq <= expire && ctl_q.ie;
    end

    assign cnt_o = cnt_q;
    assign rld_o = rld_q;
    assign ctl_o = ctl_q;
endmodule

// File: rtl/tmr_rdmux.sv
module tmr_rdmux
    import tmr_pkg::*;
#(
    parameter int unsigned NCH = 2,
    parameter int unsigned CW  = 32,
    parameter int unsigned PW  = 16
) (
    input  logic [7:0]    addr,
    input  logic [PW-1:0] pre_cnt,
    input  logic [PW-1:0] pre_rld,
    input  logic [DW-1:0] cap,
    input  logic [CW-1:0] cnt  [NCH],
    input  logic [CW-1:0] rld  [NCH],
    input  logic [DW-1:0] ctlw [NCH],
    output logic [DW-1:0] data
);
    logic [3:0] slot;
    word_e      word;

    always_comb begin
        slot = addr[7:4];
        word = word_e'(addr[3:2]);
        data = '0;
        if (addr[1:0] == 2'b00) begin
            if (slot == 4'd0) begin
                case (word)
                    W_VAL:   data = DW'(pre_cnt);
                    W_RLD:   data = DW'(pre_rld);
                    W_CTL:   data = cap;
                    default: data = '0;
                endcase
            end
            for (int i = 0; i < int'(NCH); i++) begin
                if (slot == 4'(i + 1)) begin
                    case (word)
                        W_VAL:   data = DW'(cnt[i]);
                        W_RLD:   data = DW'(rld[i]);
                        W_CTL:   data = ctlw[i];
                        default: data = '0;
                    endcase
                end
            end
        end
    end
endmodule

// File: rtl/tmr_unit.sv
module tmr_unit
    import tmr_pkg::*;
#(
    parameter int unsigned NCH      = 2,
    parameter int unsigned IRQ_BASE = 8,
    parameter int unsigned CW       = 32,
    parameter int unsigned PW       = 16
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           sel,
    input  logic           we,
    input  logic [7:0]     addr,
    input  logic [31:0]    wdata,
    output logic [31:0]    rdata,
    output logic [NCH-1:0] irq
);
    localparam logic [DW-1:0] CAP = cap_word(NCH, IRQ_BASE);

    logic          wr_ok;
    word_e         word;
    logic          tick;
    logic [PW-1:0] pre_cnt;
    logic [PW-1:0] pre_rld;
    logic [CW-1:0] cnt  [NCH];
    logic [CW-1:0] rld  [NCH];
    logic [DW-1:0] ctlw [NCH];
    logic [DW-1:0] rd_mux;
    logic [NCH-1:0] ip_vec;
    logic [NCH-1:0] en_vec;
    logic [NCH-1:0] rs_vec;

    assign wr_ok = sel && we && (addr[1:0] == 2'b00);
    assign word  = word_e'(addr[3:2]);

    tmr_prescaler #(.PW(PW)) u_pre (
        .clk    (clk),
        .rst    (rst),
        .wr_val (wr_ok && addr[7:4] == 4'd0 && word == W_VAL),
        .wr_rld (wr_ok && addr[7:4] == 4'd0 && word == W_RLD),
        .wdata  (wdata[PW-1:0]),
        .tick   (tick),
        .cnt_o  (pre_cnt),
        .rld_o  (pre_rld)
    );

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        logic    hit;
        ch_ctl_t ctl;
        assign hit = wr_ok && (addr[7:4] == 4'(i + 1));

        tmr_channel #(.CW(CW)) u_ch (
            .clk    (clk),
            .rst    (rst),
            .tick   (tick),
            .wr_cnt (hit && word == W_VAL),
            .wr_rld (hit && word == W_RLD),
            .wr_ctl (hit && word == W_CTL),
            .wdata  (wdata[CW-1:0]),
            .cnt_o  (cnt[i]),
            .rld_o  (rld[i]),
            .ctl_o  (ctl),
            .irq    (irq[i])
        );

        assign ctlw[i]   = ctl_to_word(ctl);
        assign ip_vec[i] = ctl.ip;
        assign en_vec[i] = ctl.en;
        assign rs_vec[i] = ctl.rs;
    end

    tmr_rdmux #(.NCH(NCH), .CW(CW), .PW(PW)) u_rd (
        .addr    (addr),
        .pre_cnt (pre_cnt),
        .pre_rld (pre_rld),
        .cap     (CAP),
        .cnt     (cnt),
        .rld     (rld),
        .ctlw    (ctlw),
        .data    (rd_mux)
    );

    always_ff @(posedge clk) begin
        if (rst) rdata <= '0;
        else     rdata <= (sel && !we) ? rd_mux : '0;
    end
endmodule

// File: rtl/tmr_unit_chk.sv
module tmr_unit_chk #(
    parameter int unsigned NCH      = 2,
    parameter int unsigned IRQ_BASE = 8
) (
    input logic           clk,
    input logic           rst,
    input logic           sel,
    input logic           we,
    input logic [7:0]     addr,
    input logic [31:0]    wdata,
    input logic [31:0]    rdata,
    input logic [NCH-1:0] irq,
    input logic [NCH-1:0] ip_vec,
    input logic [NCH-1:0] en_vec,
    input logic [NCH-1:0] rs_vec
);
    localparam logic [31:0] CAPX = {22'd0, 1'b1, 1'b1, 5'(IRQ_BASE), 3'(NCH)};

    // R2
    cap_const_chk: assert property (@(posedge clk) disable iff (rst)
        $past(sel && !we && addr == 8'h08) |-> rdata == CAPX);

    // R3
    misalign_zero_chk: assert property (@(posedge clk) disable iff (rst)
        $past(sel && !we && addr[1:0] != 2'b00) |-> rdata == 32'd0);

    for (genvar i = 0; i < NCH; i++) begin : g_c
        localparam logic [7:0] CA = 8'((i + 1) * 16 + 8);

        // R6
        irq_pend_chk: assert property (@(posedge clk) disable iff (rst)
            irq[i] |-> ip_vec[i]);

        // R8
        pend_clear_chk: assert property (@(posedge clk) disable iff (rst)
            $fell(ip_vec[i]) |-> $past(sel && we && addr == CA && wdata[4]));

        // R7
        oneshot_stop_chk: assert property (@(posedge clk) disable iff (rst)
            (irq[i] && !rs_vec[i]) |-> !en_vec[i]);
    end
endmodule

bind tmr_unit tmr_unit_chk #(.NCH(NCH), .IRQ_BASE(IRQ_BASE)) u_chk (
    .clk    (clk),
    .rst    (rst),
    .sel    (sel),
    .we     (we),
    .addr   (addr),
    .wdata  (wdata),
    .rdata  (rdata),
    .irq    (irq),
    .ip_vec (ip_vec),
    .en_vec (en_vec),
    .rs_vec (rs_vec)
);

// File: tb/sim_tmr_unit.sv
module sim_tmr_unit;
    localparam int NCH = 2;
    localparam logic [31:0] EN = 32'h01, RS = 32'h02, LD = 32'h04, IE = 32'h08, IP = 32'h10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sel = 1'b0;
    logic        we  = 1'b0;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [NCH-1:0] irq;

    int total = 0;
    int bad   = 0;

    always #2 clk = ~clk;

    tmr_unit #(.NCH(NCH)) u0 (
        .clk(clk), .rst(rst), .sel(sel), .we(we), .addr(addr),
        .wdata(wdata), .rdata(rdata), .irq(irq)
    );

    // {prescaler reload, count, restart}
    localparam logic [47:0] VEC [0:5] = '{
        {16'd0, 16'd0,  16'd0},
        {16'd0, 16'd5,  16'd1},
        {16'd3, 16'd2,  16'd0},
        {16'd1, 16'd7,  16'd1},
        {16'd2, 16'd0,  16'd1},
        {16'd0, 16'd31, 16'd0}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        sel = 1'b1; we = 1'b1; addr = a; wdata = d;
        @(posedge clk);
    endtask

    task automatic idle();
        @(negedge clk);
        sel = 1'b0; we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        sel = 1'b1; we = 1'b0; addr = a;
        @(posedge clk);
        @(negedge clk);
        sel = 1'b0;
        d = rdata;
    endtask

    // counts falling edges after the last write until irq[ch] is seen
    task automatic wait_irq(input int ch, input int lim, output int m);
        m = 0;
        for (int c = 1; c <= lim; c++) begin
            @(negedge clk);
            sel = 1'b0; we = 1'b0;
            if (irq[ch]) begin
                m = c;
                break;
            end
        end
    endtask

    initial begin
        logic [31:0] v;
        int m, exp_m, p, n, r, ch, j0, seen;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        rd(8'h00, v); chk("R1 prescaler value", v, 0);
        rd(8'h04, v); chk("R1 prescaler reload", v, 0);
        rd(8'h10, v); chk("R1 ch0 counter", v, 0);
        rd(8'h14, v); chk("R1 ch0 reload", v, 0);
        rd(8'h18, v); chk("R1 ch0 control", v, 0);
        rd(8'h28, v); chk("R1 ch1 control", v, 0);
        chk("R1 irq low", 32'(irq), 0);

        // R2 capability word, read-only
        rd(8'h08, v); chk("R2 capability", v, 32'h342);
        wr(8'h08, 32'hFFFF_FFFF); idle();
        rd(8'h08, v); chk("R2 capability after write", v, 32'h342);

        // R3 unmapped, nonexistent, misaligned
        rd(8'h0C, v); chk("R3 unit +0xC", v, 0);
        rd(8'h1C, v); chk("R3 ch0 +0xC", v, 0);
        wr(8'h34, 32'd7); idle();
        rd(8'h34, v); chk("R3 nonexistent channel", v, 0);
        wr(8'h15, 32'd9); idle();
        rd(8'h14, v); chk("R3 misaligned write ignored", v, 0);
        rd(8'h19, v); chk("R3 misaligned read", v, 0);

        // R4 16-bit masking, reload write loads counter
        wr(8'h04, 32'h0001_2345);
        rd(8'h00, v); chk("R4 prescaler counter loaded", v, 32'h2345);
        rd(8'h04, v); chk("R4 prescaler reload masked", v, 32'h2345);

        // R11 chain / halt bits stored, inert
        wr(8'h28, 32'h60); idle();
        rd(8'h28, v); chk("R11 bits 5,6 readback", v, 32'h60);
        rd(8'h20, v); chk("R11 counter untouched", v, 0);

        // R9 load copies reload, load bit reads 0
        wr(8'h24, 32'h77);
        wr(8'h28, LD); idle();
        rd(8'h28, v); chk("R9 load bit reads 0", v, 0);
        rd(8'h20, v); chk("R9 load copies reload", v, 32'h77);

        // R10 direct counter write, then resume while enabled
        wr(8'h20, 32'h55); idle();
        rd(8'h20, v); chk("R10 counter write", v, 32'h55);
        wr(8'h04, 32'd0);
        wr(8'h28, EN | IE);
        wr(8'h20, 32'd3);
        wait_irq(1, 100, m); chk("R10 resume from written count", m, 5);
        wr(8'h28, IP); idle();

        // R6 interrupt disabled: no line, no pending, one-shot stops
        wr(8'h14, 32'd1);
        wr(8'h18, EN | LD);
        seen = 0;
        for (int c = 0; c < 10; c++) begin
            @(negedge clk); sel = 1'b0;
            if (irq[0]) seen = 1;
        end
        chk("R6 no irq when disabled", seen, 0);
        rd(8'h18, v); chk("R6 no pending when disabled", v, 0);

        // R8 pending write-1-to-clear
        wr(8'h14, 32'd0);
        wr(8'h18, EN | IE | LD); idle();
        repeat (5) @(negedge clk);
        rd(8'h18, v); chk("R8 pending set", v, IE | IP);
        wr(8'h18, IE); idle();
        rd(8'h18, v); chk("R8 write 0 keeps pending", v, IE | IP);
        wr(8'h18, IE | IP); idle();
        rd(8'h18, v); chk("R8 write 1 clears pending", v, IE);

        // table walk: R4 R5 R6 R7
        for (int i = 0; i < 6; i++) begin
            p  = int'(VEC[i][47:32]);
            n  = int'(VEC[i][31:16]);
            r  = int'(VEC[i][15:0]);
            ch = i % 2;
            wr(8'((ch + 1) * 16 + 8), IP);
            wr(8'((ch + 1) * 16 + 4), 32'(n));
            wr(8'h04, 32'(p));
            wr(8'((ch + 1) * 16 + 8), EN | IE | LD | (r != 0 ? RS : 32'd0));
            j0 = (p == 0) ? 1 : 0;
            exp_m = p + (n + j0) * (p + 1) + 1;
            wait_irq(ch, 2000, m);
            chk($sformatf("R5 R4 expiry time vec%0d", i), m, exp_m);
            @(negedge clk);
            chk($sformatf("R6 single-cycle pulse vec%0d", i), 32'(irq[ch]), 0);
            if (r != 0) begin
                wait_irq(ch, 2000, m);
                chk($sformatf("R7 restart period vec%0d", i), m, (n + 1) * (p + 1) - 1);
                rd(8'((ch + 1) * 16 + 8), v);
                chk($sformatf("R7 restart keeps running vec%0d", i), v, EN | RS | IE | IP);
            end else begin
                seen = 0;
                for (int c = 0; c < (n + 1) * (p + 1) + 4; c++) begin
                    @(negedge clk);
                    if (irq[ch]) seen = 1;
                end
                chk($sformatf("R7 one-shot no second irq vec%0d", i), seen, 0);
                rd(8'((ch + 1) * 16 + 8), v);
                chk($sformatf("R7 one-shot stops vec%0d", i), v, IE | IP);
            end
            wr(8'((ch + 1) * 16 + 8), IP); idle();
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule